// File: doc/BRIEF.md
# Wide-Word Pattern Playback Engine

The engine streams a stored bit pattern out of an external memory that delivers one wide word (1024 bits by default) per read. After a start pulse it issues word reads in address order, places the returned words in a small prefetch buffer and shifts each word out four bits per clock onto four parallel lanes, which a later stage multiplexes to line rate. When the last word of the programmed length has been sent, playback continues with word zero, and a one-clock frame marker flags the first beat of every pass through the pattern.

The pattern length is given in words. Before starting, the engine checks it against a granularity rule: short patterns may have any length, and longer ones must be a multiple of a step that doubles each time the size passes the next power of two. A length that breaks the rule is refused: an error flag is raised and nothing is read. Playback runs until reset. If the memory falls behind and a word is missing at a word boundary, the lanes pause and a sticky flag records the underrun.

Top module: `upp_engine`

## Requirements
- R1: Within a word, beat b (b = 0..255) drives lane j with word bit 4b+j, so bit k of a word appears on lane k mod 4 and bits leave LSB-first. A word occupies 256 consecutive valid beats.
- R2: Words are read (`rd_addr`) and played in the order 0, 1, ..., L-1, then 0 again, where L is the length latched at the accepted start.
- R3: `frame_trig` is high for exactly one clock, together with `lane_valid`, on the beat that carries bits 0..3 of word 0, once per pass, so with no stall consecutive markers are 256*L clocks apart.
- R4: Any length from 1 to 1024 words is accepted by a start pulse: `busy` rises one clock later and `config_error` stays low.
- R5: A length L above 1024 words is accepted only if L is a multiple of 2^n, where n is the smallest integer with L <= 1024*2^n; otherwise the start is refused.
- R6: A length of 0 or above 2^20 words, or one breaking R5, makes a start set `config_error`, leaves `busy` low and issues no reads.
- R7: With a read latency of 1 to 8 clocks, once the first beat appears `lane_valid` stays high without a gap and `underrun` stays low; reads in flight never exceed the free prefetch slots.
- R8: If no word is buffered at a word boundary after playback has begun, `lane_valid` drops, `underrun` is set and stays set, and playback resumes with the next word in order when data arrives.
- R9: A start pulse while playing is ignored; an accepted start clears `config_error` and `underrun`.
- R10: After reset, `busy`, `rd_req`, `lane_valid`, `frame_trig`, `config_error` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| pat_len_words | input | 21 | Pattern length in words |
| rd_req | output | 1 | Word read request, one per word |
| rd_addr | output | 20 | Word address of the request |
| rd_valid | input | 1 | Read data valid, responses in request order |
| rd_data | input | 1024 | Returned word |
| lane_data | output | 4 | Four output lanes, lane j on bit j |
| lane_valid | output | 1 | Lanes carry pattern bits this clock |
| frame_trig | output | 1 | Marks the first beat of word 0 |
| busy | output | 1 | Playback running |
| config_error | output | 1 | Last start refused for its length |
| underrun | output | 1 | Sticky: a word was missing at a boundary |

## Verification
The bench sweeps the granularity edges on both sides of each power of two (1024/1025, 2049/2052, 2^20 and just past it) plus seeded random lengths, checked against an independent step rule; a wrong boundary would accept or refuse the wrong length. Short patterns of one, three and five words with fixed and random latency expose a wrap that skips or repeats word zero, a frame marker that drifts from the first beat, or a lane order that is reversed. A held-off memory forces an underrun, where a faulty design would drop a word or clear the flag, and a second start during playback would, if obeyed, restart or reject the running pattern.

// File: rtl/upp_pkg.sv
package upp_pkg;
  typedef enum logic [0:0] {
    UPP_IDLE = 1'b0,
    UPP_RUN  = 1'b1
  } upp_state_e;
endpackage

// File: rtl/upp_len_check.sv
module upp_len_check #(
  parameter int ADDR_W    = 20,
  parameter int FREE_LOG2 = 10,
  localparam int LEN_W    = ADDR_W + 1
) (
  input  logic [LEN_W-1:0] len,
  output logic             ok
);
  localparam int STEPS = ADDR_W - FREE_LOG2;

  logic [LEN_W-1:0] lo_b;
  logic [LEN_W-1:0] hi_b;
  logic [LEN_W-1:0] msk;

  always_comb begin
    ok   = (len != '0) && (len <= (LEN_W'(1) << ADDR_W));
    lo_b = '0;
    hi_b = '0;
    msk  = '0;
    for (int k = 1; k <= STEPS; k++) begin
      lo_b = LEN_W'(1) << (FREE_LOG2 + k - 1);
      hi_b = LEN_W'(1) << (FREE_LOG2 + k);
      msk  = (LEN_W'(1) << k) - LEN_W'(1);
      if ((len > lo_b) && (len <= hi_b) && ((len & msk) != '0)) ok = 1'b0;
    end
  end
endmodule

// File: rtl/upp_word_fifo.sv
module upp_word_fifo #(
  parameter int WORD_W = 1024,
  parameter int DEPTH  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr;
  logic [PTR_W-1:0]  rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  assign head = mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && !pop && (count == CNT_W'(DEPTH))));
  // R8
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop && (count == '0)));
endmodule

// File: rtl/upp_fetch.sv
module upp_fetch #(
  parameter int ADDR_W = 20,
  parameter int DEPTH  = 2,
  localparam int LEN_W = ADDR_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [LEN_W-1:0]  len,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              rd_valid,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [CNT_W-1:0]  outst;
  logic [ADDR_W-1:0] next_addr;
  logic [CNT_W:0]    used;
  logic              issue;
  logic [ADDR_W-1:0] last_addr;

  assign used      = {1'b0, fifo_count} + {1'b0, outst};
  assign issue     = run && (used < (CNT_W + 1)'(DEPTH));
  assign last_addr = ADDR_W'(len - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      next_addr <= '0;
      outst     <= '0;
    end else begin
      rd_req <= issue;
      if (issue) begin
        rd_addr   <= next_addr;
        next_addr <= (next_addr == last_addr) ? '0 : next_addr + 1'b1;
      end
      case ({issue, rd_valid})
        2'b10:   outst <= outst + 1'b1;
        2'b01:   outst <= outst - 1'b1;
        default: outst <= outst;
      endcase
    end
  end

  // R7
  rsp_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (outst != '0));
  // R2
  addr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ({1'b0, rd_addr} < len));
endmodule

// File: rtl/upp_serializer.sv
module upp_serializer #(
  parameter int WORD_W = 1024,
  parameter int LANES  = 4,
  parameter int ADDR_W = 20,
  localparam int LEN_W  = ADDR_W + 1,
  localparam int BEATS  = WORD_W / LANES,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] head,
  input  logic              fifo_empty,
  output logic              pop,
  output logic [LANES-1:0]  lane_data,
  output logic              lane_valid,
  output logic              frame_trig,
  output logic              underrun_set
);
  logic [BEAT_W-1:0] beat;
  logic [ADDR_W-1:0] widx;
  logic              primed;
  logic              have;
  logic              last_beat;
  logic [ADDR_W-1:0] last_word;

  assign last_beat    = (beat == BEAT_W'(BEATS - 1));
  assign last_word    = ADDR_W'(len - LEN_W'(1));
  assign have         = run && !((beat == '0) && fifo_empty);
  assign pop          = have && last_beat;
  assign underrun_set = run && primed && (beat == '0) && fifo_empty;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      beat       <= '0;
      widx       <= '0;
      primed     <= 1'b0;
      lane_data  <= '0;
      lane_valid <= 1'b0;
      frame_trig <= 1'b0;
    end else begin
      lane_valid <= have;
      frame_trig <= have && (beat == '0) && (widx == '0);
      if (have) begin
        lane_data <= head[int'(beat) * LANES +: LANES];
        primed    <= 1'b1;
        beat      <= last_beat ? '0 : beat + 1'b1;
        if (last_beat) widx <= (widx == last_word) ? '0 : widx + 1'b1;
      end
    end
  end

  // R3
  frame_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    frame_trig |-> lane_valid);
  // R3
  frame_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_trig |=> !frame_trig);
endmodule

// File: rtl/upp_engine.sv
module upp_engine #(
  parameter int WORD_W    = 1024,
  parameter int LANES     = 4,
  parameter int ADDR_W    = 20,
  parameter int FREE_LOG2 = 10,
  parameter int DEPTH     = 2,
  localparam int LEN_W    = ADDR_W + 1,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  pat_len_words,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic [LANES-1:0]  lane_data,
  output logic              lane_valid,
  output logic              frame_trig,
  output logic              busy,
  output logic              config_error,
  output logic              underrun
);
  import upp_pkg::*;

  upp_state_e        state;
  logic [LEN_W-1:0]  len_q;
  logic              len_ok;
  logic              run;
  logic              accept;
  logic [WORD_W-1:0] head;
  logic [CNT_W-1:0]  fifo_count;
  logic              pop;
  logic              underrun_set;

  assign run    = (state == UPP_RUN);
  assign busy   = run;
  assign accept = start && !run && len_ok;

  upp_len_check #(.ADDR_W(ADDR_W), .FREE_LOG2(FREE_LOG2)) u_len (
    .len (pat_len_words),
    .ok  (len_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= UPP_IDLE;
      len_q        <= LEN_W'(1);
      config_error <= 1'b0;
      underrun     <= 1'b0;
    end else begin
      if (start && !run) begin
        if (len_ok) begin
          state        <= UPP_RUN;
          len_q        <= pat_len_words;
          config_error <= 1'b0;
          underrun     <= 1'b0;
        end else begin
          config_error <= 1'b1;
        end
      end else if (underrun_set) begin
        underrun <= 1'b1;
      end
    end
  end

  upp_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .len        (len_q),
    .fifo_count (fifo_count),
    .rd_valid   (rd_valid),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr)
  );

  upp_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (rd_valid),
    .wdata (rd_data),
    .pop   (pop),
    .head  (head),
    .count (fifo_count)
  );

  upp_serializer #(.WORD_W(WORD_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_ser (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .len          (len_q),
    .head         (head),
    .fifo_empty   (fifo_count == '0),
    .pop          (pop),
    .lane_data    (lane_data),
    .lane_valid   (lane_valid),
    .frame_trig   (frame_trig),
    .underrun_set (underrun_set)
  );

  // R6
  refuse_bad_len_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !len_ok) |=> (config_error && !busy));
  // R6
  idle_no_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req);
  // R8
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underrun && !start) |=> underrun);
  // R9
  busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy);
endmodule

// File: tb/sim_upp_engine.sv
module sim_upp_engine;
  localparam int WORD_W = 1024;
  localparam int BEATS  = 256;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [20:0]       pat_len = 21'd1;
  logic              rd_req;
  logic [19:0]       rd_addr;
  logic              rd_valid;
  logic [WORD_W-1:0] rd_data;
  logic [3:0]        lane_data;
  logic              lane_valid, frame_trig, busy, config_error, underrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  upp_engine u0 (
    .clk(clk), .rst(rst), .start(start), .pat_len_words(pat_len),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .lane_data(lane_data), .lane_valid(lane_valid), .frame_trig(frame_trig),
    .busy(busy), .config_error(config_error), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] word_of(input int a);
    logic [WORD_W-1:0] w;
    for (int i = 0; i < WORD_W / 32; i++)
      w[i*32 +: 32] = (32'(a) + 32'd1) * 32'h9E3779B1 ^ (32'(i) * 32'h7F4A7C15) ^ {16'(a), 16'(i)};
    return w;
  endfunction

  function automatic bit exp_ok(input int l);
    int size, step;
    if (l == 0 || l > (1 << 20)) return 0;
    size = 1024; step = 1;
    while (l > size) begin size = size * 2; step = step * 2; end
    return (l % step) == 0;
  endfunction

  // memory model
  int  cyc = 0;
  int  lat = 4;
  bit  rand_lat = 0;
  bit  hold = 0;
  int  addr_q[$];
  int  due_q[$];
  int  exp_addr = 0;
  int  addr_err = 0;
  int  mon_len = 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      addr_q.delete(); due_q.delete();
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (rd_req) begin
        if (int'(rd_addr) != exp_addr) addr_err++;
        exp_addr = (exp_addr + 1 == mon_len) ? 0 : exp_addr + 1;
        addr_q.push_back(int'(rd_addr));
        due_q.push_back(cyc + (rand_lat ? int'($urandom % 8) + 1 : lat));
      end
      if (addr_q.size() > 0 && !hold && cyc >= due_q[0]) begin
        rd_valid <= 1'b1;
        rd_data  <= word_of(addr_q.pop_front());
        void'(due_q.pop_front());
      end else begin
        rd_valid <= 1'b0;
      end
    end
  end

  // output monitor
  bit  mon_en = 0;
  bit  started = 0;
  bit  expect_gapless = 1;
  int  exp_w = 0, exp_beat = 0, word_err = 0, gaps = 0, frames = 0, last_frame = -1;
  logic [WORD_W-1:0] cur_word;

  always @(negedge clk) begin
    if (mon_en) begin
      if (lane_valid) begin
        started = 1;
        if (lane_data != cur_word[exp_beat*4 +: 4]) word_err++;
        if (frame_trig || (exp_w == 0 && exp_beat == 0)) begin
          // R3
          chk(frame_trig == (exp_w == 0 && exp_beat == 0), "R3 frame position",
              frame_trig, exp_w == 0 && exp_beat == 0);
          if (frame_trig) begin
            if (last_frame >= 0 && expect_gapless)
              chk(cyc - last_frame == mon_len * BEATS, "R3 frame spacing",
                  cyc - last_frame, mon_len * BEATS);
            last_frame = cyc;
            frames++;
          end
        end
        exp_beat++;
        if (exp_beat == BEATS) begin
          // R1 lane mapping per word, R2 word order
          chk(word_err == 0, "R1 word content", word_err, 0);
          word_err = 0;
          exp_beat = 0;
          exp_w = (exp_w + 1 == mon_len) ? 0 : exp_w + 1;
          cur_word = word_of(exp_w);
        end
      end else begin
        if (frame_trig) chk(0, "R3 frame without data", 1, 0);
        if (started) gaps++;
      end
    end
  end

  task automatic do_reset();
    mon_en = 0;
    rst = 1; start = 0; hold = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic pulse_start(input int l);
    pat_len = 21'(l);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic arm_monitor(input int l);
    mon_len = l; exp_addr = 0; addr_err = 0;
    exp_w = 0; exp_beat = 0; word_err = 0; gaps = 0; frames = 0; last_frame = -1;
    started = 0; expect_gapless = 1;
    cur_word = word_of(0);
    mon_en = 1;
  endtask

  task automatic try_len(input int l);
    bit e;
    do_reset();
    e = exp_ok(l);
    pulse_start(l);
    if (l != 0 && l <= 1024) begin
      // R4
      chk(busy == 1'b1 && config_error == 1'b0, "R4 short length accepted", busy, 1);
    end else begin
      // R5 granularity, R6 refusal
      chk(busy == e, "R5 length acceptance", busy, e);
      chk(config_error == !e, "R6 config_error", config_error, !e);
    end
  endtask

  task automatic play(input int l, input int la, input bit rl, input int ncyc);
    do_reset();
    lat = la; rand_lat = rl;
    arm_monitor(l);
    pulse_start(l);
    repeat (ncyc) @(negedge clk);
    chk(frames >= ncyc / (l * BEATS) - 1, "R3 frame count", frames, ncyc / (l * BEATS) - 1);
    chk(addr_err == 0, "R2 read address order", addr_err, 0);
    // R7
    chk(gaps == 0, "R7 gapless output", gaps, 0);
    chk(underrun == 1'b0, "R7 no underrun", underrun, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R10
    chk(!busy && !rd_req && !lane_valid && !frame_trig && !config_error && !underrun,
        "R10 reset state", {busy, rd_req, lane_valid, frame_trig, config_error, underrun}, 0);

    // R6 zero length: refused, nothing fetched
    pulse_start(0);
    repeat (4) @(negedge clk);
    chk(config_error == 1'b1 && busy == 1'b0, "R6 zero length refused", config_error, 1);
    chk(rd_req == 1'b0 && lane_valid == 1'b0, "R6 no reads when refused", rd_req, 0);
    // R9 accepted start clears config_error
    pulse_start(2);
    chk(config_error == 1'b0 && busy == 1'b1, "R9 error cleared by accepted start", config_error, 0);

    // granularity edges
    try_len(1); try_len(1024); try_len(1025); try_len(1026);
    try_len(2048); try_len(2049); try_len(2050); try_len(2052);
    try_len(4100); try_len(4104); try_len(1048576); try_len(1048577);
    try_len(1047552); try_len(1047553); try_len(2097151); try_len(524800);
    for (int n = 0; n < 40; n++) begin
      int e, l, m;
      e = int'($urandom % 21);
      m = int'($urandom % 11);
      l = int'($urandom % (1 << e)) + (1 << e) / 2 + 1;
      l = l & ~((1 << m) - 1);
      if (l == 0) l = 1 << m;
      try_len(l);
    end

    // playback patterns
    play(3, 3, 0, 3000);
    // R9 start during playback is ignored
    pulse_start(0);
    repeat (900) @(negedge clk);
    chk(config_error == 1'b0 && busy == 1'b1, "R9 start ignored while playing", config_error, 0);
    chk(gaps == 0 && addr_err == 0, "R9 stream unaffected", gaps + addr_err, 0);

    play(1, 8, 0, 1300);
    play(5, 1, 1, 3000);

    // R8 underrun
    do_reset();
    lat = 2; rand_lat = 0;
    arm_monitor(4);
    expect_gapless = 0;
    pulse_start(4);
    repeat (300) @(negedge clk);
    chk(underrun == 1'b0, "R8 no underrun before stall", underrun, 0);
    hold = 1;
    repeat (900) @(negedge clk);
    chk(underrun == 1'b1, "R8 underrun raised", underrun, 1);
    chk(lane_valid == 1'b0, "R8 lanes paused", lane_valid, 0);
    hold = 0;
    repeat (1500) @(negedge clk);
    chk(underrun == 1'b1, "R8 underrun sticky", underrun, 1);
    chk(gaps > 0 && addr_err == 0, "R8 resumed in order", addr_err, 0);
    chk(frames >= 2, "R8 frame after resume", frames, 2);
    // R9 accepted start clears underrun (after reset-free restart is impossible; check via reset path)
    do_reset();
    chk(underrun == 1'b0, "R10 underrun cleared by reset", underrun, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule